// File: doc/BRIEF.md
# Full-Duplex Synchronous Serial Transceiver

This block is a clocked-serial master that shifts one byte out and one byte in during every frame. A processor drives it through four byte-wide registers on a simple write-strobe and read-strobe interface. The transmit path is double-buffered. A byte written to the transmit holding register moves into the shift register as soon as the engine is free. Software can then load the next byte while the current one is still being shifted.

A write to the transmit holding register is the only start command. Each completed frame delivers its received byte to a receive holding register and pulses an interrupt line. If a byte completes while the previous one is still unread, the overrun flag is set. The new byte is then dropped, and no further frame starts until software clears the flag.

The shift engine is a four-state machine:
- `ST_IDLE`: the serial clock is held low. The engine leaves this state (transition *start*) when a byte is pending, the transmitter is enabled and no overrun is flagged.
- `ST_LOW`: serial clock low, output bit driven. It moves on (*rise*) after one half period.
- `ST_HIGH`: serial clock high, input bit sampled on entry. After one half period it returns to `ST_LOW` (*fall*) or, after the eighth bit, goes to `ST_FINISH` (*last*).
- `ST_FINISH`: a single cycle that hands the received byte to the registers. It returns to `ST_IDLE` (*wrap*).

Clearing the transmit enable forces any state back to `ST_IDLE` (*abort*).

Register map (2-bit address `addr`):
- 0: control. Bit 0 is the transmit enable, bit 1 the receive enable, and bits 7:4 the half-period select.
- 1: status.
- 2: transmit holding register.
- 3: receive holding register.

Top module: `fdx_serial_xcvr`

## Requirements
- R1: After reset the status register (address 1) reads 0x01, meaning only bit 0 (transmit-empty) is set. The receive holding register (address 3) reads 0x00, and `sck` and `irq_rx` are low.
- R2: A write to address 2 clears status bit 0 (transmit-empty). With the transmitter disabled (control bit 0 = 0) the byte waits and `sck` does not toggle.
- R3: When a byte is pending, control bit 0 is 1 and overrun is 0, a frame starts on the next cycle. The byte moves into the shift register and status bit 0 returns to 1. A byte written during the frame is sent in the immediately following frame.
- R4: A frame shifts 8 bits MSB first on `mosi`. `sck` idles low and `mosi` changes only while `sck` is low. `miso` is sampled as `sck` rises.
- R5: When a frame ends with the receiver enabled (control bit 1 = 1) and status bit 1 (receive-full) at 0, the received byte goes to address 3, receive-full is set, and `irq_rx` pulses high for one cycle.
- R6: Reading address 3 returns the stored byte and clears receive-full. A read in the same cycle as a frame end returns the old byte, stores the new one, and leaves overrun at 0.
- R7: When a frame ends while receive-full is 1 and no read occurs, status bit 2 (overrun) is set. The old byte is kept, the new byte is dropped, and `irq_rx` stays low.
- R8: While overrun is 1, no frame starts. Writing address 1 with bit 2 = 0 clears it, and writing bit 2 = 1 has no effect. A pending byte then starts its frame.
- R9: Status bit 3 (transmit-end) is set when a frame ends with no byte pending. It is cleared by writing address 1 with bit 3 = 0, or by any write to address 2.
- R10: Clearing control bit 0 aborts a frame and returns `sck` low. The holding registers keep their contents. On re-enable, a pending byte is sent whole, MSB first.
- R11: With control bit 1 = 0, completed frames leave address 3, receive-full, overrun and `irq_rx` untouched, and transmission still proceeds.
- R12: Control bits 7:4 hold a value N, and the serial clock period is 2*(N+1) system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on address 3) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq_rx | output | 1 | One-cycle pulse per stored received byte |

## Verification
Two functions can land in one clock edge: a software read of the receive holding register, and the frame-end hand-off of a new byte. The bench counts eight rising serial clock edges plus one half period and one cycle after a transfer is started. It then asserts the read strobe exactly in the `ST_FINISH` cycle. The result is judged by the byte returned (the old one), by the status afterwards (receive-full set, overrun clear) and by the new byte being readable next, together with one more interrupt pulse.

// File: rtl/fdx_pkg.sv
`timescale 1ns/1ps
package fdx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_FINISH
    } fdx_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_TXD  = 2'd2;
    localparam logic [1:0] A_RXD  = 2'd3;

    localparam int B_TXE  = 0;
    localparam int B_RXF  = 1;
    localparam int B_OVR  = 2;
    localparam int B_TEND = 3;

    localparam int B_TXEN = 0;
    localparam int B_RXEN = 1;

endpackage

// File: rtl/fdx_half_timer.sv
`timescale 1ns/1ps
module fdx_half_timer #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] half_sel,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || cnt_q == '0) begin
            cnt_q <= half_sel;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = !restart && (cnt_q == '0);

endmodule

// File: rtl/fdx_shift_engine.sv
`timescale 1ns/1ps
module fdx_shift_engine
    import fdx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              start_ok,
    input  logic [DATA_W-1:0] tdr_data,
    input  logic              miso,
    input  logic              tick,
    output logic              restart,
    output logic              load,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sck,
    output logic              mosi
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    fdx_state_e state_q, state_d;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic [CNT_W-1:0]  bit_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tx_en && start_ok) state_d = ST_LOW;
            ST_LOW:    if (tick) state_d = ST_HIGH;
            ST_HIGH:   if (tick) state_d = (bit_q == LAST) ? ST_FINISH : ST_LOW;
            ST_FINISH: state_d = ST_IDLE;
        endcase
        if (!tx_en) state_d = ST_IDLE;
    end

    // outputs decoded from state
    always_comb begin
        load    = 1'b0;
        done    = 1'b0;
        sck     = 1'b0;
        restart = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                restart = 1'b1;
                load    = tx_en && start_ok;
            end
            ST_LOW:    restart = !tx_en;
            ST_HIGH: begin
                sck     = 1'b1;
                restart = !tx_en;
            end
            ST_FINISH: begin
                done    = 1'b1;
                restart = 1'b1;
            end
        endcase
    end

    // shift datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            bit_q   <= '0;
        end else if (!tx_en) begin
            bit_q <= '0;
        end else begin
            if (load) begin
                tx_sh_q <= tdr_data;
                bit_q   <= '0;
            end
            if (state_q == ST_LOW && tick) begin
                rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
            end
            if (state_q == ST_HIGH && tick && bit_q != LAST) begin
                tx_sh_q <= tx_sh_q << 1;
                bit_q   <= bit_q + 1'b1;
            end
        end
    end

    assign mosi    = tx_sh_q[DATA_W-1];
    assign rx_byte = rx_sh_q;

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (state_q == ST_IDLE) && !sck);

    // R4
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> bit_q == LAST);

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck && $past(sck) |-> $stable(mosi));

endmodule

// File: rtl/fdx_regs.sv
`timescale 1ns/1ps
module fdx_regs
    import fdx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              load,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              tx_en,
    output logic [DIV_W-1:0]  half_sel,
    output logic              start_ok,
    output logic [DATA_W-1:0] tdr_out,
    output logic              irq
);

    localparam int DIV_LSB = DATA_W - DIV_W;

    logic [DATA_W-1:0] ctrl_q, tdr_q, rdr_q;
    logic tdr_full_q, rx_full_q, ovr_q, tend_q, irq_q;
    logic ctrl_wr, st_wr, tdr_wr, rd_clear, rx_en, accept, ovr_set;

    assign ctrl_wr  = wr_en && addr == A_CTRL;
    assign st_wr    = wr_en && addr == A_STAT;
    assign tdr_wr   = wr_en && addr == A_TXD;
    assign rd_clear = rd_en && addr == A_RXD;
    assign rx_en    = ctrl_q[B_RXEN];
    assign accept   = done && rx_en;
    assign ovr_set  = accept && rx_full_q && !rd_clear;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            tdr_q      <= '0;
            rdr_q      <= '0;
            tdr_full_q <= 1'b0;
            rx_full_q  <= 1'b0;
            ovr_q      <= 1'b0;
            tend_q     <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (ctrl_wr) ctrl_q <= wdata;
            if (tdr_wr)  tdr_q  <= wdata;

            if (tdr_wr)    tdr_full_q <= 1'b1;
            else if (load) tdr_full_q <= 1'b0;

            if (accept && !ovr_set) begin
                rdr_q     <= rx_byte;
                rx_full_q <= 1'b1;
                irq_q     <= 1'b1;
            end else if (rd_clear) begin
                rx_full_q <= 1'b0;
            end

            if (ovr_set)                     ovr_q <= 1'b1;
            else if (st_wr && !wdata[B_OVR]) ovr_q <= 1'b0;

            if (tdr_wr)                       tend_q <= 1'b0;
            else if (done && !tdr_full_q)     tend_q <= 1'b1;
            else if (st_wr && !wdata[B_TEND]) tend_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL: rdata = ctrl_q;
            A_STAT: rdata = {{(DATA_W-4){1'b0}}, tend_q, ovr_q, rx_full_q, ~tdr_full_q};
            A_TXD:  rdata = tdr_q;
            A_RXD:  rdata = rdr_q;
        endcase
    end

    assign tx_en    = ctrl_q[B_TXEN];
    assign half_sel = ctrl_q[DIV_LSB +: DIV_W];
    assign start_ok = tdr_full_q && !ovr_q;
    assign tdr_out  = tdr_q;
    assign irq      = irq_q;

    // R5
    irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> rx_full_q);

    // R9
    tend_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tend_q |-> !tdr_full_q);

    // R7
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> $stable(rdr_q));

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q && !st_wr |=> ovr_q);

endmodule

// File: rtl/fdx_serial_xcvr.sv
`timescale 1ns/1ps
module fdx_serial_xcvr #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              irq_rx
);

    logic tx_en, start_ok, load, done, restart, tick;
    logic [DIV_W-1:0]  half_sel;
    logic [DATA_W-1:0] tdr_data, rx_byte;

    fdx_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .load(load), .done(done), .rx_byte(rx_byte),
        .tx_en(tx_en), .half_sel(half_sel), .start_ok(start_ok),
        .tdr_out(tdr_data), .irq(irq_rx)
    );

    fdx_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .half_sel(half_sel), .tick(tick)
    );

    fdx_shift_engine #(.DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .start_ok(start_ok),
        .tdr_data(tdr_data), .miso(miso), .tick(tick), .restart(restart),
        .load(load), .done(done), .rx_byte(rx_byte), .sck(sck), .mosi(mosi)
    );

    // R3
    load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load && !sck);

endmodule

// File: tb/fdx_serial_xcvr_tb.sv
`timescale 1ns/1ps
module fdx_serial_xcvr_tb_top;

    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic sck, mosi, miso, irq_rx;

    int total = 0;
    int bad = 0;
    int irq_cnt = 0;
    int sck_edges = 0;
    int s_bits = 0;
    logic [7:0] s_tx = 8'h00;
    logic [7:0] s_cap = 8'h00;
    logic [7:0] exp_mosi[$];
    logic [7:0] miso_q[$];

    always #2.5 clk = ~clk;

    assign miso = s_tx[7];

    fdx_serial_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso),
        .irq_rx(irq_rx)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // driver: pushes the expected serial output byte
    task automatic send(input logic [7:0] d);
        exp_mosi.push_back(d);
        cpu_wr(2'd2, d);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input string req, input int exp_cyc);
        realtime t0, t1;
        @(posedge sck); t0 = $realtime;
        @(posedge sck); t1 = $realtime;
        chk(req, 8'(int'((t1 - t0) / 5.0)), 8'(exp_cyc));
    endtask

    // slave model and monitor: pops expected bytes and compares
    initial begin
        forever begin
            @(posedge sck);
            sck_edges++;
            s_cap = {s_cap[6:0], mosi};
            s_tx  = s_tx << 1;
            s_bits++;
            if (s_bits == 8) begin
                s_bits = 0;
                if (exp_mosi.size() > 0) chk("R4 mosi byte", s_cap, exp_mosi.pop_front());
                else chk("R4 unexpected frame", s_cap, 8'hxx);
                if (miso_q.size() > 0) s_tx = miso_q.pop_front();
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (irq_rx) irq_cnt++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int e0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cpu_rd(2'd1, v); chk("R1 status", v, 8'h01);
        cpu_rd(2'd3, v); chk("R1 rx data", v, 8'h00);
        chk("R1 sck", {7'd0, sck}, 8'h00);
        chk("R1 irq", {7'd0, irq_rx}, 8'h00);

        // R2 write while disabled
        cpu_wr(2'd0, 8'h30);
        s_tx = 8'h3C;
        send(8'hA5);
        cpu_rd(2'd1, v); chk("R2 empty cleared", v, 8'h00);
        wait_cyc(20);
        chk("R2 no clock while disabled", 8'(sck_edges), 8'h00);

        // R3 enable starts, double buffering
        cpu_wr(2'd0, 8'h33);
        wait_cyc(5);
        cpu_rd(2'd1, v); chk("R3 moved to shifter", v, 8'h01);
        miso_q.push_back(8'hC3);
        send(8'h5A);
        cpu_rd(2'd1, v); chk("R3 second byte pending", v, 8'h00);
        wait_cyc(170);
        cpu_rd(2'd1, v); chk("R7 overrun status", v, 8'h0F);
        chk("R7 single irq", 8'(irq_cnt), 8'd1);
        cpu_rd(2'd3, v); chk("R7 old byte kept", v, 8'h3C);
        cpu_rd(2'd1, v); chk("R6 read clears full", v, 8'h0D);

        // R8 overrun stall
        s_tx = 8'h7E;
        send(8'h81);
        cpu_rd(2'd1, v); chk("R9 tend cleared by write", v, 8'h04);
        e0 = sck_edges;
        wait_cyc(100);
        chk("R8 stalled", 8'(sck_edges - e0), 8'h00);
        cpu_wr(2'd1, 8'h04);
        cpu_rd(2'd1, v); chk("R8 write one ignored", v, 8'h04);
        cpu_wr(2'd1, 8'h00);
        wait_cyc(80);
        cpu_rd(2'd1, v); chk("R5 full after frame", v, 8'h0B);
        chk("R5 irq pulse", 8'(irq_cnt), 8'd2);
        cpu_rd(2'd3, v); chk("R5 rx byte", v, 8'h7E);
        cpu_wr(2'd1, 8'h00);
        cpu_rd(2'd1, v); chk("R9 tend cleared by status", v, 8'h01);

        // R6 read in the frame-end cycle
        s_tx = 8'h22;
        send(8'h11);
        wait_cyc(80);
        cpu_rd(2'd1, v); chk("R5 full again", v, 8'h0B);
        cpu_wr(2'd1, 8'h00);
        s_tx = 8'h44;
        send(8'h33);
        repeat (8) @(posedge sck);
        wait_cyc(HALF);
        cpu_rd(2'd3, v); chk("R6 same-cycle read old", v, 8'h22);
        wait_cyc(5);
        cpu_rd(2'd1, v); chk("R6 no overrun on coincide", v, 8'h0B);
        chk("R6 irq count", 8'(irq_cnt), 8'd4);
        cpu_rd(2'd3, v); chk("R6 new byte", v, 8'h44);

        // R10 abort
        s_tx = 8'h00;
        send(8'h96);
        wait_cyc(20);
        cpu_wr(2'd0, 8'h32);
        wait_cyc(2);
        chk("R10 sck idle", {7'd0, sck}, 8'h00);
        s_bits = 0;
        void'(exp_mosi.pop_front());
        e0 = sck_edges;
        send(8'hC9);
        wait_cyc(20);
        chk("R10 no clock", 8'(sck_edges - e0), 8'h00);
        cpu_rd(2'd1, v); chk("R10 byte held", v, 8'h00);
        cpu_rd(2'd3, v); chk("R10 rx kept", v, 8'h44);
        s_tx = 8'h5D;
        cpu_wr(2'd0, 8'h33);
        wait_cyc(80);
        cpu_rd(2'd3, v); chk("R10 resumed frame rx", v, 8'h5D);

        // R11 receiver disabled, R12 period
        cpu_wr(2'd0, 8'h31);
        s_tx = 8'h99;
        send(8'hE7);
        measure("R12 period half=4", 8);
        wait_cyc(80);
        cpu_rd(2'd1, v); chk("R11 status", v, 8'h09);
        chk("R11 no irq", 8'(irq_cnt), 8'd5);
        cpu_rd(2'd3, v); chk("R11 rx untouched", v, 8'h5D);

        cpu_wr(2'd0, 8'h13);
        s_tx = 8'h00;
        send(8'h42);
        measure("R12 period half=2", 4);
        wait_cyc(60);
        chk("R4 all bytes seen", 8'(exp_mosi.size()), 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule